// File: doc/BRIEF.md
# Mono-Select Half-Rate I2S Reframer

This block sits between a stereo I2S source and a single-channel converter stage. It is an I2S slave and runs entirely on the incoming bit clock. It takes one channel of each incoming stereo frame and sends that sample out again on a second I2S port. The output port carries a 16-bit sample in a 16-bit slot, while the input carries it left-justified in a 32-bit slot. The output bit clock is exactly half the input bit clock, so the frame rate does not change.

The half-rate clock is not a free-running toggle. Every falling edge of the input word select forces the divider into a fixed phase. After any slip, glitch or power-up state, the output clock therefore realigns within one input frame, and no separate reset pulse is needed for this. A static select input chooses whether the left or the right input slot is taken. The captured sample is sent in both output slots of the following output frame.

Top module: `mono_reframer`

## Requirements
- R1: While reset is asserted, and afterwards until the first falling edge of the input word select has been sampled, `bckOut`, `wsOut` and `sdOut` stay low.
- R2: Input bit positions are counted from the input rising edge that first samples word select low (position 0). `bckOut` is high after the input rising edges that sample odd positions and low after those that sample even positions. Its first rising edge therefore coincides with the sampling of the left-slot MSB (position 1), and it has 32 periods per frame.
- R3: Every sampled falling edge of the input word select forces `bckOut` low and restarts the position count, whatever phase the divider had before. An odd-length slip of the input frame is corrected in the next frame.
- R4: With `selRight` = 0, the sample is taken from input positions 1..16 (left slot). With `selRight` = 1, it is taken from positions 33..48 (right slot). In both cases the MSB arrives first.
- R5: The 16 lower bits of each 32-bit input slot have no effect on the output.
- R6: In each output frame, the sample is sent MSB first on the `bckOut` rising edges numbered 0..15 (left slot). It is sent again on edges 16..31 (right slot). `sdOut` changes only while `bckOut` is low.
- R7: `wsOut` is low for the left output slot and high for the right output slot. It changes one output clock before each slot's MSB: it goes high after input position 30 and low after input position 62.
- R8: The sample captured in input frame N is sent in output frame N+1. The first output frame after reset carries zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bckIn | input | 1 | Input bit clock; every register is clocked on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wsIn | input | 1 | Input word select (low = left slot) |
| sdIn | input | 1 | Input serial data, 32-bit slots, MSB first |
| selRight | input | 1 | Channel select: 0 = left, 1 = right |
| bckOut | output | 1 | Half-rate output bit clock |
| wsOut | output | 1 | Output word select (low = left slot) |
| sdOut | output | 1 | Output serial data, 16-bit slots, MSB first |

## Verification
The bench builds the block with the default sample width of 16. This gives the standard 64-clock input frame and the 32-clock output frame, so every slot boundary, capture point and word-select transition falls within a short run. At that size, a table of ten frames covers both channel choices and low halves that differ under equal upper halves. It also covers input slips of one, two and three bit clocks, which show that the divider locks its phase on each frame and not only once.

// File: rtl/reframer_pkg.sv
package reframer_pkg;
  typedef struct packed {
    logic capture;
    logic loadLeft;
    logic loadRight;
    logic shiftOut;
  } strobe_t;
endpackage

// File: rtl/reframer_ctrl.sv
module reframer_ctrl
  import reframer_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wsIn,
  input  logic    selRight,
  output logic    bckOut,
  output logic    wsOut,
  output strobe_t stb
);
  localparam int FRAME_LEN = 4 * SAMPLE_W;
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] P_LEFT_END   = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] P_RIGHT_END  = CNT_W'(3 * SAMPLE_W);
  localparam logic [CNT_W-1:0] P_RIGHT_LOAD = CNT_W'(2 * SAMPLE_W);
  localparam logic [CNT_W-1:0] P_WS_SET     = CNT_W'(2 * SAMPLE_W - 2);
  localparam logic [CNT_W-1:0] P_WS_CLR     = CNT_W'(4 * SAMPLE_W - 2);

  logic             wsDly;
  logic             locked;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pos;
  logic             wsFall;
  logic             active;

  always_comb begin
    wsFall = wsDly & ~wsIn;
    pos    = wsFall ? '0 : cnt;
    active = locked | wsFall;
    stb.capture   = active && (pos == (selRight ? P_RIGHT_END : P_LEFT_END));
    stb.loadLeft  = active && (pos == '0);
    stb.loadRight = active && (pos == P_RIGHT_LOAD);
    stb.shiftOut  = active && !pos[0] && (pos != '0) && (pos != P_RIGHT_LOAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsDly  <= 1'b0;
      locked <= 1'b0;
      cnt    <= '0;
      bckOut <= 1'b0;
      wsOut  <= 1'b0;
    end else begin
      wsDly  <= wsIn;
      locked <= active;
      cnt    <= pos + 1'b1;
      bckOut <= active ? pos[0] : 1'b0;
      if (active && pos == P_WS_SET) wsOut <= 1'b1;
      else if (active && pos == P_WS_CLR) wsOut <= 1'b0;
    end
  end

  // R2: once locked, the output clock flips on every input edge without a frame restart
  a_r2_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !wsFall) |=> (bckOut != $past(bckOut)));

  // R3: a word-select fall always restarts the divider in its low phase
  a_r3_relock: assert property (@(posedge clk) disable iff (!rstN)
    wsFall |=> !bckOut);

  // R7: output word select moves only together with a falling output clock
  a_r7_ws_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wsOut) |-> $fell(bckOut));

  // R6: at most one output-register action per input edge
  a_r6_one_out_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadLeft, stb.loadRight, stb.shiftOut}));
endmodule

// File: rtl/reframer_data.sv
module reframer_data
  import reframer_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sdIn,
  input  strobe_t stb,
  output logic    sdOut
);
  logic [SAMPLE_W-1:0] shiftIn;
  logic [SAMPLE_W-1:0] capReg;
  logic [SAMPLE_W-1:0] txHold;
  logic [SAMPLE_W-1:0] outSh;
  logic [SAMPLE_W-1:0] shiftNext;

  assign shiftNext = {shiftIn[SAMPLE_W-2:0], sdIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
      capReg  <= '0;
      txHold  <= '0;
      outSh   <= '0;
      sdOut   <= 1'b0;
    end else begin
      shiftIn <= shiftNext;
      if (stb.capture) capReg <= shiftNext;
      if (stb.loadLeft) begin
        txHold <= capReg;
        sdOut  <= capReg[SAMPLE_W-1];
        outSh  <= {capReg[SAMPLE_W-2:0], 1'b0};
      end else if (stb.loadRight) begin
        sdOut  <= txHold[SAMPLE_W-1];
        outSh  <= {txHold[SAMPLE_W-2:0], 1'b0};
      end else if (stb.shiftOut) begin
        sdOut  <= outSh[SAMPLE_W-1];
        outSh  <= {outSh[SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  // R6: the right output slot repeats the word held since the left slot began
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadLeft |=> $stable(txHold));
endmodule

// File: rtl/mono_reframer.sv
module mono_reframer
  import reframer_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic bckIn,
  input  logic rstN,
  input  logic wsIn,
  input  logic sdIn,
  input  logic selRight,
  output logic bckOut,
  output logic wsOut,
  output logic sdOut
);
  strobe_t stb;

  reframer_ctrl #(.SAMPLE_W(SAMPLE_W)) i_ctrl (
    .clk(bckIn), .rstN(rstN), .wsIn(wsIn), .selRight(selRight),
    .bckOut(bckOut), .wsOut(wsOut), .stb(stb)
  );

  reframer_data #(.SAMPLE_W(SAMPLE_W)) i_data (
    .clk(bckIn), .rstN(rstN), .sdIn(sdIn), .stb(stb), .sdOut(sdOut)
  );

  // R6: serial data changes only in the low phase of the output clock
  a_r6_sd_low_phase: assert property (@(posedge bckIn) disable iff (!rstN)
    !$stable(sdOut) |-> !bckOut);
endmodule

// File: tb/test_mono_reframer.sv
module test_mono_reframer;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 10;
  localparam logic [31:0] L_TAB [NF] = '{32'hA5A5_1234, 32'hFFFF_0000, 32'h8001_AAAA,
    32'h8001_5555, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0001_FFFE, 32'h5A5A_0000,
    32'h7FFF_0001, 32'h0000_0000};
  localparam logic [31:0] R_TAB [NF] = '{32'h3C3C_0F0F, 32'h0000_FFFF, 32'h7FFE_5555,
    32'h1234_0000, 32'hFFFF_FFFF, 32'hCAFE_F00D, 32'h8000_0001, 32'hA5A5_0000,
    32'h4321_8888, 32'h0000_0000};
  localparam logic SEL_TAB [NF] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int PAD_TAB [NF] = '{0, 0, 0, 1, 0, 2, 3, 0, 1, 0};

  logic bckIn = 1'b0, rstN = 1'b0, wsIn = 1'b1, sdIn = 1'b0, selRight = 1'b0;
  logic bckOut, wsOut, sdOut;
  int checks = 0, errors = 0;
  logic obck [64];
  logic ows [64];
  logic osd [64];
  logic lastSd = 1'b0;

  mono_reframer i_mono_reframer (
    .bckIn(bckIn), .rstN(rstN), .wsIn(wsIn), .sdIn(sdIn), .selRight(selRight),
    .bckOut(bckOut), .wsOut(wsOut), .sdOut(sdOut)
  );

  always #(CLK_PERIOD / 2) bckIn = ~bckIn;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic ws, input logic sd, input int p);
    @(negedge bckIn);
    wsIn = ws;
    sdIn = sd;
    @(posedge bckIn);
    #1;
    if (p >= 0) begin
      obck[p] = bckOut;
      ows[p]  = wsOut;
      osd[p]  = sdOut;
    end
  endtask

  task automatic sendFrame(input logic [31:0] l, input logic [31:0] r, input logic sel);
    for (int p = 0; p < 64; p++) begin
      if (p == 0) selRight = sel;
      if (p == 0) sendBit(1'b0, lastSd, p);
      else if (p <= 32) sendBit(p == 32, l[32-p], p);
      else sendBit(1'b1, r[64-p], p);
    end
    lastSd = r[0];
  endtask

  task automatic checkFrame(input logic [15:0] expW, input string tag);
    int badClk = 0, badWs = 0;
    logic [15:0] lw, rw;
    for (int p = 0; p < 64; p++) begin
      if (obck[p] != p[0]) badClk++;
      if (ows[p] != (p >= 30 && p <= 61)) badWs++;
    end
    for (int j = 0; j < 16; j++) begin
      lw[15-j] = osd[2*j+1];
      rw[15-j] = osd[2*j+33];
    end
    check(badClk == 0, {"R2 R3 clock phase ", tag}, badClk, 0);
    check(badWs == 0, {"R7 word select ", tag}, badWs, 0);
    check(lw == expW, {"R4 R5 R6 R8 left slot ", tag}, lw, expW);
    check(rw == expW, {"R6 right slot repeat ", tag}, rw, expW);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] expW;
    bit allLow;
    // R1: outputs in reset
    repeat (4) @(negedge bckIn);
    check({bckOut, wsOut, sdOut} == 3'b000, "R1 in reset", {bckOut, wsOut, sdOut}, 0);
    rstN = 1'b1;
    // R1: not yet locked, word select held high
    allLow = 1;
    for (int k = 0; k < 12; k++) begin
      sendBit(1'b1, k[0], -1);
      if ({bckOut, wsOut, sdOut} != 3'b000) allLow = 0;
    end
    check(allLow, "R1 before first word-select fall", allLow, 1);

    // table walk: output of frame f carries frame f-1 selection (zero for f = 0, R8)
    expW = 16'h0000;
    for (int f = 0; f < NF; f++) begin
      for (int k = 0; k < PAD_TAB[f]; k++) sendBit(1'b1, 1'b0, -1);  // R3 slip
      sendFrame(L_TAB[f], R_TAB[f], SEL_TAB[f]);
      checkFrame(expW, $sformatf("frame %0d", f));
      expW = SEL_TAB[f] ? R_TAB[f][31:16] : L_TAB[f][31:16];
    end

    // R5: only low halves differ between two frames; output must follow upper halves
    sendFrame(32'h6C6C_FFFF, 32'h0000_0000, 1'b0);
    checkFrame(expW, "R5 setup");
    sendFrame(32'h6C6C_0000, 32'h0000_0000, 1'b0);
    checkFrame(16'h6C6C, "R5 low half ffff");
    sendFrame(32'h0000_0000, 32'h0000_0000, 1'b0);
    checkFrame(16'h6C6C, "R5 low half 0000");

    // R1 and R8: reset mid-stream clears outputs and the held sample
    sendFrame(32'hBEEF_0000, 32'h0000_0000, 1'b0);
    @(negedge bckIn);
    rstN = 1'b0;
    @(negedge bckIn);
    check({bckOut, wsOut, sdOut} == 3'b000, "R1 mid-run reset", {bckOut, wsOut, sdOut}, 0);
    rstN = 1'b1;
    lastSd = 1'b0;
    for (int k = 0; k < 3; k++) sendBit(1'b1, 1'b0, -1);
    sendFrame(32'h1111_0000, 32'h2222_0000, 1'b1);
    checkFrame(16'h0000, "R8 first frame after reset");
    sendFrame(32'h0000_0000, 32'h0000_0000, 1'b0);
    checkFrame(16'h2222, "R4 right after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule